// File: doc/BRIEF.md
# Depth-Cascaded Pipelined RAM Array

This block is a wide on-chip memory assembled from a grid of identical 64-bit RAM tiles. Tiles in a row sit side by side to form the full data word (`LANES` × 64 bits). Rows are chained to reach the full capacity, and each row holds 2^`TILE_AW` words. At the full build the tiles hold 4096 words each, and 8 lanes by 16 rows give 4 MB. The default parameters give a much smaller array.

Read data does not fan in through one wide multiplexer. It flows down the row chain instead. Each row either substitutes its own tile output, when it owns the requested address, or forwards what the previous row handed it. A register follows every second row. The read and write requests travel down the chain in step with the data. Each row therefore sees its reads and writes in issue order, and the total read latency is a fixed number that depends only on the row count: `ROWS/2 + 2` cycles when there are two or more rows, and 1 cycle when there is a single row.

The block has one write port and one read port, and both accept a new request every cycle. A read-valid strobe marks the cycle in which each read's data is presented.

Top module: `cram_cascade`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `rd_valid` is 0 and `rd_data` is all zeros.
- R2: A read accepted at a rising clock edge raises `rd_valid` for exactly one cycle, and presents its data, after `LAT-1` further rising edges. LAT is `ROWS/2+2` for `ROWS` ≥ 2 and 1 for `ROWS` = 1. A cycle with `rd_en` low produces no `rd_valid`.
- R3: Address bits `[TILE_AW-1:0]` select the word inside a tile, and the bits above them select the row. Every address maps to its own storage, so each of the 2^(TILE_AW+log2 ROWS) words reads back the last data written to it.
- R4: Bit i of `wr_be` enables byte i, which is `wr_data[8i+7:8i]`. Bytes whose enable is 0 keep their previous content.
- R5: A read and a write to the same address in the same cycle return the data that was stored before the write.
- R6: A read issued in the cycle after a write to the same address returns the newly written data, including when the address lies in a far row.
- R7: Reads may be issued on every cycle without a gap. The data returns one word per cycle, in issue order.
- R8: A cycle with `wr_en` low changes no stored data, whatever `wr_addr`, `wr_data` and `wr_be` carry.
- R9: For any one request, only the row that owns the address captures a write or drives read data onto the chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | TILE_AW+log2(ROWS) | Write word address |
| wr_data | input | LANES*64 | Write data |
| wr_be | input | LANES*8 | Write byte enables, one per byte |
| rd_en | input | 1 | Read request |
| rd_addr | input | TILE_AW+log2(ROWS) | Read word address |
| rd_data | output | LANES*64 | Read data, valid when rd_valid is high |
| rd_valid | output | 1 | Marks the cycle that carries a read's data |

## Verification
The hardest situation to reach is a read that sits in flight while a write to the same word enters the pipeline behind it. The read must reach a far row in a later cycle than the write enters the block, yet it must still return the old data. A write followed at once by a read must also see the new data, even though both take several cycles to reach the owning row. The stimulus reaches these cases in three ways. It pairs same-cycle reads and writes to addresses in the last row. It issues a write immediately followed by a read of the same address. It runs a long random mix with back-to-back traffic confined to a few addresses, so that reads and writes to one word keep overlapping in the chain.

// File: rtl/cram_pkg.sv
package cram_pkg;

    // Total read latency for a cascade with the given number of rows.
    function automatic int cram_latency(input int rows);
        return (rows <= 1) ? 1 : (rows / 2 + 2);
    endfunction

    // Number of request pipeline stages, one per pair of rows.
    function automatic int cram_stages(input int rows);
        return (rows <= 1) ? 1 : (rows / 2);
    endfunction

endpackage

// File: rtl/cram_tile.sv
// One narrow RAM tile: simple dual port, byte writes, registered read-first output.
module cram_tile #(
    parameter int WORD_W = 64,
    parameter int AW     = 6
) (
    input  logic                  clk,
    input  logic                  we,
    input  logic [AW-1:0]         waddr,
    input  logic [WORD_W-1:0]     wdata,
    input  logic [WORD_W/8-1:0]   wbe,
    input  logic                  re,
    input  logic [AW-1:0]         raddr,
    output logic [WORD_W-1:0]     rdata
);
    localparam int WORDS = 2 ** AW;
    localparam int NBYTE = WORD_W / 8;

    logic [WORD_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < NBYTE; b++) begin
                if (wbe[b]) begin
                    mem[waddr][b*8 +: 8] <= wdata[b*8 +: 8];
                end
            end
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/cram_row.sv
// One row of tiles: address ownership, tile bank, chain substitution and an optional stage register.
module cram_row #(
    parameter int LANE_W  = 64,
    parameter int LANES   = 2,
    parameter int TILE_AW = 6,
    parameter int SEL_W   = 2,
    parameter int ROW_IDX = 0,
    parameter int OUT_REG = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [TILE_AW+SEL_W-1:0]      wr_addr,
    input  logic [LANE_W*LANES-1:0]       wr_data,
    input  logic [LANE_W*LANES/8-1:0]     wr_be,
    input  logic                          rd_en,
    input  logic [TILE_AW+SEL_W-1:0]      rd_addr,
    input  logic [LANE_W*LANES-1:0]       chain_in,
    output logic [LANE_W*LANES-1:0]       chain_out,
    output logic                          rd_own,
    output logic                          wr_hit
);
    localparam int AW  = TILE_AW + SEL_W;
    localparam int DW  = LANE_W * LANES;
    localparam int LBW = LANE_W / 8;

    typedef struct packed {
        logic own;
    } row_ctl_t;

    row_ctl_t ctl_d, ctl_q;
    logic     wr_row, rd_row, rd_take;
    logic [DW-1:0] tile_q;
    logic [DW-1:0] chain_mux;

    generate
        if (SEL_W == 0) begin : g_single
            assign wr_row = 1'b1;
            assign rd_row = 1'b1;
        end else begin : g_sel
            assign wr_row = (wr_addr[AW-1:TILE_AW] == SEL_W'(ROW_IDX));
            assign rd_row = (rd_addr[AW-1:TILE_AW] == SEL_W'(ROW_IDX));
        end
    endgenerate

    assign wr_hit  = wr_en & wr_row;
    assign rd_take = rd_en & rd_row;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            cram_tile #(
                .WORD_W (LANE_W),
                .AW     (TILE_AW)
            ) u_tile (
                .clk   (clk),
                .we    (wr_hit),
                .waddr (wr_addr[TILE_AW-1:0]),
                .wdata (wr_data[l*LANE_W +: LANE_W]),
                .wbe   (wr_be[l*LBW +: LBW]),
                .re    (rd_take),
                .raddr (rd_addr[TILE_AW-1:0]),
                .rdata (tile_q[l*LANE_W +: LANE_W])
            );
        end
    endgenerate

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.own = rd_take;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign rd_own    = ctl_q.own;
    assign chain_mux = ctl_q.own ? tile_q : chain_in;

    generate
        if (OUT_REG != 0) begin : g_reg
            logic [DW-1:0] chain_d, chain_q;

            always_comb begin
                chain_d = chain_mux;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= chain_d;
            end

            assign chain_out = chain_q;
        end else begin : g_pass
            assign chain_out = chain_mux;
        end
    endgenerate

endmodule

// File: rtl/cram_cascade.sv
// Top: request pipeline along the row chain, row instances and read-valid delay line.
module cram_cascade #(
    parameter int LANE_W  = 64,
    parameter int LANES   = 2,
    parameter int ROWS    = 4,
    parameter int TILE_AW = 6
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [TILE_AW+$clog2(ROWS)-1:0]      wr_addr,
    input  logic [LANE_W*LANES-1:0]              wr_data,
    input  logic [LANE_W*LANES/8-1:0]            wr_be,
    input  logic                                 rd_en,
    input  logic [TILE_AW+$clog2(ROWS)-1:0]      rd_addr,
    output logic [LANE_W*LANES-1:0]              rd_data,
    output logic                                 rd_valid
);
    localparam int SEL_W   = $clog2(ROWS);
    localparam int AW      = TILE_AW + SEL_W;
    localparam int DW      = LANE_W * LANES;
    localparam int BW      = DW / 8;
    localparam int STAGES  = cram_pkg::cram_stages(ROWS);
    localparam int LATENCY = cram_pkg::cram_latency(ROWS);
    localparam bit IN_REG  = (ROWS > 1);

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] wa;
        logic [DW-1:0] wd;
        logic [BW-1:0] be;
        logic          rd;
        logic [AW-1:0] ra;
    } req_t;

    typedef struct packed {
        req_t [STAGES-1:0]  stage;
        logic [LATENCY-1:0] vld;
    } top_t;

    top_t top_d, top_q;
    req_t port_req;
    req_t req_at [STAGES];

    logic [DW-1:0]   chain [ROWS+1];
    logic [ROWS-1:0] row_rd_own;
    logic [ROWS-1:0] row_wr_hit;

    always_comb begin
        port_req.wr = wr_en;
        port_req.wa = wr_addr;
        port_req.wd = wr_data;
        port_req.be = wr_be;
        port_req.rd = rd_en;
        port_req.ra = rd_addr;
    end

    always_comb begin
        top_d          = top_q;
        top_d.stage[0] = port_req;
        for (int s = 1; s < STAGES; s++) begin
            top_d.stage[s] = top_q.stage[s-1];
        end
        top_d.vld[0] = rd_en;
        for (int i = 1; i < LATENCY; i++) begin
            top_d.vld[i] = top_q.vld[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (IN_REG) begin : g_piped
                assign req_at[s] = top_q.stage[s];
            end else begin : g_direct
                assign req_at[s] = port_req;
            end
        end
    endgenerate

    assign chain[0] = '0;

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            cram_row #(
                .LANE_W  (LANE_W),
                .LANES   (LANES),
                .TILE_AW (TILE_AW),
                .SEL_W   (SEL_W),
                .ROW_IDX (r),
                .OUT_REG ((r % 2 == 1) ? 1 : 0)
            ) u_row (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_en     (req_at[r/2].wr),
                .wr_addr   (req_at[r/2].wa),
                .wr_data   (req_at[r/2].wd),
                .wr_be     (req_at[r/2].be),
                .rd_en     (req_at[r/2].rd),
                .rd_addr   (req_at[r/2].ra),
                .chain_in  (chain[r]),
                .chain_out (chain[r+1]),
                .rd_own    (row_rd_own[r]),
                .wr_hit    (row_wr_hit[r])
            );
        end
    endgenerate

    assign rd_data  = chain[ROWS];
    assign rd_valid = top_q.vld[LATENCY-1];

endmodule

// File: rtl/cram_cascade_chk.sv
// Protocol and decode checks, attached to every cram_cascade instance.
module cram_cascade_chk #(
    parameter int ROWS = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rd_en,
    input logic            rd_valid,
    input logic [ROWS-1:0] row_rd_own,
    input logic [ROWS-1:0] row_wr_hit
);
    localparam int LATENCY = cram_pkg::cram_latency(ROWS);
    localparam int CW      = $clog2(LATENCY + 2) + 1;

    logic [CW-1:0] inflight_q, idle_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight_q <= '0;
            idle_q     <= CW'(LATENCY);
        end else begin
            inflight_q <= inflight_q + CW'(rd_en) - CW'(rd_valid);
            if (rd_en)                     idle_q <= '0;
            else if (idle_q < CW'(LATENCY)) idle_q <= idle_q + 1'b1;
        end
    end

    AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q <= CW'(LATENCY)); // R7

    AST_VALID_HAS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (inflight_q != '0)); // R2

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_q >= CW'(LATENCY)) |-> !rd_valid); // R2

    generate
        for (genvar s = 0; s < ROWS / 2; s++) begin : g_pair
            AST_ONE_READ_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(row_rd_own[2*s +: 2])); // R9

            AST_ONE_WRITE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(row_wr_hit[2*s +: 2])); // R9
        end
    endgenerate

endmodule

bind cram_cascade cram_cascade_chk #(
    .ROWS (ROWS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rd_valid   (rd_valid),
    .row_rd_own (row_rd_own),
    .row_wr_hit (row_wr_hit)
);

// File: tb/sim_cram_cascade.sv
`timescale 1ns/1ps
module sim_cram_cascade;
    localparam int LANE_W  = 64;
    localparam int LANES   = 2;
    localparam int ROWS    = 4;
    localparam int TILE_AW = 6;
    localparam int AW      = TILE_AW + $clog2(ROWS);
    localparam int DW      = LANE_W * LANES;
    localparam int BW      = DW / 8;
    localparam int WORDS   = 2 ** AW;
    localparam int LAT     = (ROWS == 1) ? 1 : (ROWS / 2 + 2);

    typedef struct {
        int            due;
        logic [DW-1:0] data;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en, rd_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [DW-1:0] wr_data;
    logic [BW-1:0] wr_be;
    logic [DW-1:0] rd_data;
    logic          rd_valid;

    int   total = 0;
    int   bad   = 0;
    int   edges = 0;
    bit   done  = 0;
    string cur_tag = "R1";

    logic [DW-1:0] mdl [WORDS];
    exp_t          expq [$];

    always #2 clk = ~clk;
    always @(posedge clk) edges++;

    cram_cascade #(
        .LANE_W  (LANE_W),
        .LANES   (LANES),
        .ROWS    (ROWS),
        .TILE_AW (TILE_AW)
    ) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_be    (wr_be),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    function automatic logic [DW-1:0] rnd_word();
        logic [DW-1:0] w;
        for (int i = 0; i < DW / 32; i++) w[i*32 +: 32] = $urandom;
        return w;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // Compare the outputs after the latest edge against the reference queue.
    task automatic compare_outputs();
        bit exp_v;
        exp_v = (expq.size() > 0) && (expq[0].due == edges);
        check(rd_valid == exp_v, cur_tag, "rd_valid", DW'(rd_valid), DW'(exp_v));
        if (exp_v) begin
            check(rd_data == expq[0].data, cur_tag, "rd_data", rd_data, expq[0].data);
            void'(expq.pop_front());
        end
    endtask

    // One clock: compare, then drive the next request and update the model.
    task automatic cyc(input bit we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                       input logic [BW-1:0] be, input bit re, input logic [AW-1:0] ra);
        exp_t e;
        @(negedge clk);
        compare_outputs();
        wr_en = we; wr_addr = wa; wr_data = wd; wr_be = be;
        rd_en = re; rd_addr = ra;
        if (re) begin
            e.due  = edges + LAT;
            e.data = mdl[ra];
            expq.push_back(e);
        end
        if (we) begin
            for (int b = 0; b < BW; b++) begin
                if (be[b]) mdl[wa][b*8 +: 8] = wd[b*8 +: 8];
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, '0, '0, '0, 0, '0);
    endtask

    initial begin
        rst_n = 1'b0;
        wr_en = 0; rd_en = 0; wr_addr = '0; rd_addr = '0; wr_data = '0; wr_be = '0;
        for (int i = 0; i < WORDS; i++) mdl[i] = '0;
        void'($urandom(11));

        // R1: reset state, during reset and in the first cycle after release
        repeat (3) @(negedge clk);
        check(rd_valid == 1'b0, "R1", "rd_valid in reset", DW'(rd_valid), '0);
        check(rd_data == '0, "R1", "rd_data in reset", rd_data, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_valid == 1'b0, "R1", "rd_valid after reset", DW'(rd_valid), '0);
        check(rd_data == '0, "R1", "rd_data after reset", rd_data, '0);

        // R3: fill every word, then read all back with gaps
        cur_tag = "R3";
        for (int a = 0; a < WORDS; a++) cyc(1, AW'(a), rnd_word(), '1, 0, '0);
        for (int a = 0; a < WORDS; a++) begin
            cyc(0, '0, '0, '0, 1, AW'(a));
            cyc(0, '0, '0, '0, 0, '0);
        end
        idle(LAT + 1);

        // R2: isolated reads, exact latency and single-cycle valid
        cur_tag = "R2";
        for (int k = 0; k < 4; k++) begin
            cyc(0, '0, '0, '0, 1, AW'($urandom_range(0, WORDS - 1)));
            idle(LAT + 2);
        end

        // R7: back-to-back reads across all rows
        cur_tag = "R7";
        for (int k = 0; k < 64; k++) cyc(0, '0, '0, '0, 1, AW'($urandom_range(0, WORDS - 1)));
        idle(LAT + 1);

        // R4: partial byte-enable writes, then read back
        cur_tag = "R4";
        for (int k = 0; k < 24; k++) begin
            logic [AW-1:0] a;
            a = AW'($urandom_range(0, WORDS - 1));
            cyc(1, a, rnd_word(), BW'($urandom), 0, '0);
            cyc(0, '0, '0, '0, 1, a);
        end
        cyc(1, AW'(5), rnd_word(), '0, 0, '0);
        cyc(0, '0, '0, '0, 1, AW'(5));
        idle(LAT + 1);

        // R5: same-cycle read and write of one address, including the last row
        cur_tag = "R5";
        for (int k = 0; k < 16; k++) begin
            logic [AW-1:0] a;
            a = (k < 8) ? AW'(WORDS - 1 - k) : AW'($urandom_range(0, WORDS - 1));
            cyc(1, a, rnd_word(), '1, 1, a);
        end
        idle(LAT + 1);

        // R6: write then read in the next cycle, far rows first
        cur_tag = "R6";
        for (int k = 0; k < 16; k++) begin
            logic [AW-1:0] a;
            a = (k < 8) ? AW'(WORDS - 1 - 2 * k) : AW'($urandom_range(0, WORDS - 1));
            cyc(1, a, rnd_word(), BW'($urandom), 0, '0);
            cyc(0, '0, '0, '0, 1, a);
        end
        idle(LAT + 1);

        // R8: disabled writes with live address, data and enables, then read back
        cur_tag = "R8";
        for (int k = 0; k < 16; k++) begin
            logic [AW-1:0] a;
            a = AW'($urandom_range(0, WORDS - 1));
            cyc(0, a, rnd_word(), '1, 0, a);
            cyc(0, '0, '0, '0, 1, a);
        end
        idle(LAT + 1);

        // R9: long random mix on a few hot addresses spread over the rows
        cur_tag = "R9";
        for (int k = 0; k < 3000; k++) begin
            logic [AW-1:0] wa, ra;
            wa = AW'(($urandom_range(0, 3) * (WORDS / 4)) + $urandom_range(0, 1));
            ra = AW'(($urandom_range(0, 3) * (WORDS / 4)) + $urandom_range(0, 1));
            cyc(($urandom_range(0, 1) == 1), wa, rnd_word(), BW'($urandom),
                ($urandom_range(0, 3) != 0), ra);
        end
        idle(LAT + 2);
        check(expq.size() == 0, "R7", "reads left unanswered", DW'(expq.size()), '0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog %s act=%0d exp=%0d", cur_tag, edges, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule